// File: doc/BRIEF.md
# Capture/Compare Timer Channel with Status Flags

This block is one timer channel with its flag register. A counter runs up or down against a programmable reload limit. It raises an update flag each time it wraps. The single channel works in one of two modes. In compare mode it flags when the count reaches a programmed value. In capture mode it latches the count on a chosen edge of a synchronised input pin.

The status register holds five flags: update, compare/capture, commutation, break and overcapture. Each flag has its own hardware set condition, and software clears it by writing a zero to its bit. The compare/capture flag is also cleared by reading the captured value while in capture mode. The break flag stays set for as long as the break input is held high. Mode, count direction and edge choice are static configuration pins. Bus reads return data combinationally, and bus writes take effect at the next clock edge.

Top module: `tstat_top`

## Requirements
- R1: After reset, the status register at offset 0x10 reads 0, the reload register at 0x2C reads all ones, the channel value register at 0x34 reads 0 and the count is 0. Status bits 0, 1, 5, 7 and 9 hold the update, compare/capture, commutation, break and overcapture flags, and every other status bit reads 0.
- R2: On each enabled cycle, an up-counter at the reload value wraps to 0, and a down-counter at 0 reloads the reload value. Either wrap sets the update flag (bit 0) one cycle later.
- R3: Writing the status register clears each flag whose written bit is 0, and leaves each flag whose written bit is 1 unchanged.
- R4: In compare mode, when the channel value is not above the reload value, an enabled cycle with the count equal to the channel value sets bit 1. This holds in both directions.
- R5: In compare mode, when the channel value is above the reload value, bit 1 is set on the wrap instead.
- R6: In capture mode, a selected edge on the capture pin copies the count into the channel value register and sets bit 1. The edge reaches the register on the third clock edge after the pin changes. Configuration bit 0 selects rising edges and bit 1 selects falling edges, so both bits set selects either edge. Edges that are not selected are ignored.
- R7: In capture mode, a bus read of offset 0x34 clears bit 1.
- R8: A capture that occurs while bit 1 is already set sets the overcapture flag (bit 9). This flag is never set in compare mode.
- R9: The break flag (bit 7) is set while the break input is high. A write of 0 to it has no effect while the break input is high.
- R10: A commutation pulse sets bit 5.
- R11: When a hardware set and a software clear of the same flag fall in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable |
| cfg_down | input | 1 | 1 = count down |
| cfg_capture | input | 1 | 1 = capture mode, 0 = compare mode |
| cfg_edge | input | 2 | Capture edge select: bit 0 rising, bit 1 falling |
| cap_pin | input | 1 | Asynchronous capture input |
| brk_in | input | 1 | Break input, active high |
| com_evt | input | 1 | Commutation event pulse |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data |
| cnt_val | output | CNT_W | Current count |

## Verification
The bench builds the block with its default 16-bit width. It programs a small reload value of 5, which brings every wrap in both directions within a handful of cycles. It also places the channel value on both sides of the reload value, so the equal-count and on-wrap compare rules are both reached. Holding the counter still during capture tests makes each latched count known exactly. Overcapture, blocked break clears and same-cycle set/clear collisions are driven as directed cases.

// File: rtl/tstat_pkg.sv
package tstat_pkg;
  localparam int ADDR_W     = 8;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_CHVAL  = 8'h34;
  localparam int BIT_UPD = 0;
  localparam int BIT_CC  = 1;
  localparam int BIT_COM = 5;
  localparam int BIT_BRK = 7;
  localparam int BIT_OVR = 9;

  typedef struct packed {
    logic ovr;
    logic brk;
    logic com;
    logic cc;
    logic upd;
  } flags_t;
endpackage

// File: rtl/tstat_counter.sv
module tstat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         down,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    wrap  = en && (down ? (cnt_q == '0) : (cnt_q == reload));
    cnt_d = cnt_q;
    if (en) begin
      if (down) cnt_d = wrap ? reload : cnt_q - 1'b1;
      else      cnt_d = wrap ? '0     : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  a_r2_up_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !down && cnt_q == reload) |=> (cnt_q == '0));
  a_r2_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (en && down && cnt_q == '0) |=> (cnt_q == $past(reload)));
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));
endmodule

// File: rtl/tstat_edge.sv
module tstat_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_en,
  input  logic fall_en,
  output logic hit
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_comb begin
    hit = (rise_en && s2_q && !prev_q) || (fall_en && !s2_q && prev_q);
  end

  a_r6_hit_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (s2_q != prev_q));
endmodule

// File: rtl/tstat_flags.sv
module tstat_flags
  import tstat_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t set,
  input  flags_t clr,
  input  logic   brk_active,
  output flags_t flags
);
  flags_t q, d, clr_eff;

  always_comb begin
    clr_eff     = clr;
    clr_eff.brk = clr.brk && !brk_active;
    d           = set | (q & ~clr_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign flags = q;

  a_r9_brk_holds: assert property (@(posedge clk) disable iff (!rst_n)
    brk_active |=> q.brk);
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set.com && clr.com) |=> q.com);
  a_r3_no_clear_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (q.upd && !clr.upd) |=> q.upd);
endmodule

// File: rtl/tstat_top.sv
module tstat_top
  import tstat_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             cfg_down,
  input  logic             cfg_capture,
  input  logic [1:0]       cfg_edge,
  input  logic             cap_pin,
  input  logic             brk_in,
  input  logic             com_evt,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic [CNT_W-1:0] cnt_val
);
  localparam int STAT_W = BIT_OVR + 1;

  logic [CNT_W-1:0] arr_q, arr_d, ccr_q, ccr_d, cnt;
  logic wrap, edge_hit, cmp_ev, cap_ev;
  logic wr_stat, wr_arr, wr_ccr, rd_ccr;
  flags_t fset, fclr, flags;
  logic [STAT_W-1:0] stat_vec;

  tstat_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .down(cfg_down),
    .reload(arr_q), .cnt(cnt), .wrap(wrap)
  );

  tstat_edge u_edge (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin),
    .rise_en(cfg_edge[0]), .fall_en(cfg_edge[1]), .hit(edge_hit)
  );

  always_comb begin
    wr_stat = bus_sel && bus_wr  && (bus_addr == OFS_STATUS);
    wr_arr  = bus_sel && bus_wr  && (bus_addr == OFS_RELOAD);
    wr_ccr  = bus_sel && bus_wr  && (bus_addr == OFS_CHVAL);
    rd_ccr  = bus_sel && !bus_wr && (bus_addr == OFS_CHVAL);

    cmp_ev = !cfg_capture && cnt_en &&
             ((ccr_q <= arr_q) ? (cnt == ccr_q) : wrap);
    cap_ev = cfg_capture && edge_hit;

    fset.upd = wrap;
    fset.cc  = cmp_ev || cap_ev;
    fset.ovr = cap_ev && flags.cc;
    fset.brk = brk_in;
    fset.com = com_evt;

    fclr.upd = wr_stat && !bus_wdata[BIT_UPD];
    fclr.cc  = (wr_stat && !bus_wdata[BIT_CC]) || (rd_ccr && cfg_capture);
    fclr.com = wr_stat && !bus_wdata[BIT_COM];
    fclr.brk = wr_stat && !bus_wdata[BIT_BRK];
    fclr.ovr = wr_stat && !bus_wdata[BIT_OVR];

    arr_d = wr_arr ? bus_wdata : arr_q;
    ccr_d = cap_ev ? cnt : (wr_ccr ? bus_wdata : ccr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_q <= '1;
      ccr_q <= '0;
    end else begin
      arr_q <= arr_d;
      ccr_q <= ccr_d;
    end
  end

  tstat_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set(fset), .clr(fclr),
    .brk_active(brk_in), .flags(flags)
  );

  always_comb begin
    stat_vec          = '0;
    stat_vec[BIT_UPD] = flags.upd;
    stat_vec[BIT_CC]  = flags.cc;
    stat_vec[BIT_COM] = flags.com;
    stat_vec[BIT_BRK] = flags.brk;
    stat_vec[BIT_OVR] = flags.ovr;
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFS_STATUS: bus_rdata[STAT_W-1:0] = stat_vec;
        OFS_RELOAD: bus_rdata = arr_q;
        OFS_CHVAL:  bus_rdata = ccr_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign cnt_val = cnt;

  a_r4_match_sets_cc: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_capture && cnt_en && ccr_q <= arr_q && cnt == ccr_q) |=> flags.cc);
  a_r2_wrap_sets_upd: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flags.upd);
  a_r8_no_ovr_in_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_capture && !flags.ovr && !cap_ev) |=> !flags.ovr);
  a_r6_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (ccr_q == $past(cnt)));
  a_r10_com_sets: assert property (@(posedge clk) disable iff (!rst_n)
    com_evt |=> flags.com);
endmodule

// File: tb/test_tstat_top.sv
module test_tstat_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, cfg_down = 1'b0, cfg_capture = 1'b0;
  logic [1:0] cfg_edge = 2'b01;
  logic cap_pin = 1'b0, brk_in = 1'b0, com_evt = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata, cnt_val;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  tstat_top i_tstat_top (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cfg_down(cfg_down),
    .cfg_capture(cfg_capture), .cfg_edge(cfg_edge), .cap_pin(cap_pin),
    .brk_in(brk_in), .com_evt(com_evt), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_val(cnt_val)
  );

  // op: 0 write, 1 read and compare, 2 count for data cycles
  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [7:0]  addr;
    logic [15:0] data;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'd1,  8'h2C, 16'h0005},
    '{2'd1, 4'd1,  8'h2C, 16'h0005}, // R1 reload readback
    '{2'd0, 4'd4,  8'h34, 16'h0003},
    '{2'd2, 4'd4,  8'h00, 16'd4},    // count 0..3, match at 3
    '{2'd1, 4'd4,  8'h10, 16'h0002}, // R4
    '{2'd0, 4'd3,  8'h10, 16'hFFFD},
    '{2'd1, 4'd3,  8'h10, 16'h0000}, // R3 clear by zero
    '{2'd2, 4'd2,  8'h00, 16'd2},    // 4,5 -> wrap
    '{2'd1, 4'd2,  8'h10, 16'h0001}, // R2 update flag
    '{2'd0, 4'd3,  8'h10, 16'hFFFF},
    '{2'd1, 4'd3,  8'h10, 16'h0001}, // R3 ones keep
    '{2'd0, 4'd3,  8'h10, 16'hFFFE},
    '{2'd1, 4'd3,  8'h10, 16'h0000}, // R3
    '{2'd0, 4'd5,  8'h34, 16'h0009},
    '{2'd2, 4'd5,  8'h00, 16'd6},    // 0..5 -> wrap
    '{2'd1, 4'd5,  8'h10, 16'h0003}, // R5 cc on overflow
    '{2'd0, 4'd3,  8'h10, 16'h0000},
    '{2'd1, 4'd3,  8'h10, 16'h0000}, // R3 clear all
    '{2'd1, 4'd1,  8'h34, 16'h0009}, // R1 channel value readback
    '{2'd1, 4'd1,  8'h20, 16'h0000}, // R1 unmapped offset
    '{2'd1, 4'd2,  8'h00, 16'h0000}  // dummy read of unmapped 0
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 check(tag, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic pin(input logic v);
    @(negedge clk);
    cap_pin = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd("R1 status reset", 8'h10, 16'h0000);
    rd("R1 reload reset", 8'h2C, 16'hFFFF);
    rd("R1 chval reset",  8'h34, 16'h0000);
    check("R1 count reset", cnt_val, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: wr(VEC[i].addr, VEC[i].data);
        2'd1: rd($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].addr, VEC[i].data);
        default: run(int'(VEC[i].data));
      endcase
    end

    // R2 R5 down-count underflow with channel value above reload
    cfg_down = 1'b1;
    run(1);
    check("R2 down reload", cnt_val, 16'h0005);
    rd("R5 cc on underflow", 8'h10, 16'h0003);
    wr(8'h10, 16'h0000);
    wr(8'h34, 16'h0002);
    run(3);
    rd("R4 no early match", 8'h10, 16'h0000);
    run(1);
    rd("R4 down match", 8'h10, 16'h0002);
    wr(8'h10, 16'h0000);
    cfg_down = 1'b0;
    check("R2 count after down", cnt_val, 16'h0001);

    // R6 R7 R8 capture
    cfg_capture = 1'b1; cfg_edge = 2'b01;
    pin(1'b1);
    rd("R6 rising capture flag", 8'h10, 16'h0002);
    rd("R6 captured count", 8'h34, 16'h0001);
    rd("R7 read clears cc", 8'h10, 16'h0000);
    pin(1'b0);
    rd("R6 falling ignored", 8'h10, 16'h0000);
    run(2);
    pin(1'b1);
    pin(1'b0);
    run(1);
    pin(1'b1);
    rd("R8 overcapture", 8'h10, 16'h0202);
    cfg_capture = 1'b0;
    rd("R6 second capture", 8'h34, 16'h0004);
    rd("R7 compare mode read keeps", 8'h10, 16'h0202);
    wr(8'h10, 16'h0000);
    cfg_capture = 1'b1; cfg_edge = 2'b11;
    pin(1'b0);
    rd("R6 both edges", 8'h10, 16'h0002);
    wr(8'h10, 16'h0000);
    cfg_capture = 1'b0;

    // R9 break
    @(negedge clk); brk_in = 1'b1;
    repeat (2) @(negedge clk);
    rd("R9 break set", 8'h10, 16'h0080);
    wr(8'h10, 16'h0000);
    rd("R9 clear blocked", 8'h10, 16'h0080);
    @(negedge clk); brk_in = 1'b0;
    wr(8'h10, 16'hFF7F);
    rd("R9 clear after release", 8'h10, 16'h0000);

    // R10 commutation
    @(negedge clk); com_evt = 1'b1;
    @(negedge clk); com_evt = 1'b0;
    rd("R10 com set", 8'h10, 16'h0020);
    wr(8'h10, 16'hFFDF);
    rd("R10 com cleared", 8'h10, 16'h0000);

    // R11 set and clear in the same cycle
    @(negedge clk);
    com_evt = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 16'h0000;
    @(negedge clk);
    com_evt = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd("R11 set wins", 8'h10, 16'h0020);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule